// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

The block turns a stream of parallel left/right sample pairs into a three-wire stereo audio stream: a bit clock, a channel-select line and one serial data line. Both clocks are made from the system clock by integer division. The bit clock runs at sample rate × slot width × 2. Serial data and channel select change only when the bit clock falls, so a downstream receiver can capture them on the rising bit-clock edge.

Sample pairs arrive over a valid/ready handshake into a one-entry holding register. A pair is taken at the first bit of each frame. If no pair is waiting at that point, the last pair is sent again and an underrun indication is raised for that frame. A two-bit run-time selector picks the framing. Standard mode puts the MSB one bit after the channel-select edge. Left-aligned mode puts the MSB on the edge itself. Right-aligned mode ends each sample on the last bit of its slot. Pulse mode marks the frame with a one-bit select pulse and packs both samples back to back. Sample width (16, 24 or 32) and slot width are parameters.

Top module: `audio_ser_tx`

## Requirements
- R1: `bclk_o` is low out of reset and toggles every `HALF_DIV` system clocks, so a frame of 2×`SLOT_W` bits lasts 4×`HALF_DIV`×`SLOT_W` system clocks.
- R2: `sd_o` and `ws_o` change only on the system clock edge where `bclk_o` falls; each falling edge advances the frame position by one bit, and position 0 is the first bit after reset.
- R3: With `fmt_i` = 0 (standard), `ws_o` is low for the left slot (positions 0..`SLOT_W`-1) and high for the right slot, and it takes each new value one bit early (at the last bit of the previous slot). The sample MSB is sent at slot bit 0 and the bits follow in descending order.
- R4: With `fmt_i` = 1 (left-aligned), `ws_o` is high exactly for positions `SLOT_W`..2×`SLOT_W`-1. The sample MSB is sent at slot bit 0, on the same bit as the `ws_o` change.
- R5: With `fmt_i` = 2 (right-aligned), `ws_o` behaves as in R4. The sample LSB is sent at the last bit of each slot, the MSB at slot bit `SLOT_W`-`SAMPLE_W`, and the leading bits are zero.
- R6: With `fmt_i` = 3 (pulse), `ws_o` is high only at frame position 0. The left sample occupies positions 0..`SAMPLE_W`-1, MSB first, the right sample follows at once, and every later position is zero.
- R7: In formats 0 and 1, slot bits after the sample LSB are driven as zero.
- R8: `in_ready_o` is high exactly when the holding register is empty. A pair accepted by `in_valid_i`&&`in_ready_o` is held unchanged and is sent in the next frame that starts after the acceptance edge.
- R9: If the holding register is empty at the start of a frame, the previous pair is sent again and `underrun_o` is high for that whole frame. It is cleared at the next frame start that finds a pair.
- R10: While `rst_ni` is low, `bclk_o`, `ws_o`, `sd_o` and `underrun_o` are 0 and `in_ready_o` is 1; the repeated pair after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing select: 0 standard, 1 left-aligned, 2 right-aligned, 3 pulse |
| in_valid_i | input | 1 | Sample pair valid |
| in_ready_o | output | 1 | Holding register empty |
| left_i | input | SAMPLE_W | Left sample |
| right_i | input | SAMPLE_W | Right sample |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Channel select / frame pulse |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Current frame repeats the previous pair |

## Verification
Each of the four framings is run with the same sequence. Several pairs are offered back to back, which tests how the handshake backs off and how each pair lines up with a frame. Then the input is left idle for more than two frames, which tests the repeat-and-flag path. Then new pairs are sent, which tests that the flag clears. The sample values are asymmetric in both halves and differ between left and right. A bit placed one position off, in reversed order or in the wrong slot therefore changes the serial stream. Because the model checks every system clock, it also catches an output that moves between bit-clock falls, or a bit clock with the wrong half period.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;
  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_PULSE = 2'd3
  } fmt_e;
endpackage

// File: rtl/audio_ser_bclk.sv
module audio_ser_bclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bclk_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          bclk_q;
  logic          wrap;

  assign wrap   = (cnt_q == CNT_LAST);
  assign fall_o = wrap & bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  a_r1_toggle_only_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(bclk_o));
  a_r1_toggle_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (bclk_o != $past(bclk_o)));
endmodule

// File: rtl/audio_ser_inbuf.sv
module audio_ser_inbuf #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                take_i,
  output logic                pend_vld_o,
  output logic [SAMPLE_W-1:0] pend_l_o,
  output logic [SAMPLE_W-1:0] pend_r_o
);
  logic                pend_q;
  logic [SAMPLE_W-1:0] pend_l_q, pend_r_q;
  logic                accept;

  assign in_ready_o = ~pend_q;
  assign accept     = in_valid_i & ~pend_q;
  assign pend_vld_o = pend_q;
  assign pend_l_o   = pend_l_q;
  assign pend_r_o   = pend_r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      pend_l_q <= '0;
      pend_r_q <= '0;
    end else if (accept) begin
      pend_q   <= 1'b1;
      pend_l_q <= left_i;
      pend_r_q <= right_i;
    end else if (take_i) begin
      pend_q   <= 1'b0;
    end
  end

  a_r8_hold_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !take_i |=> pend_q && $stable(pend_l_q) && $stable(pend_r_q));
  a_r8_take_needs_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q);
endmodule

// File: rtl/audio_ser_frame.sv
module audio_ser_frame
  import audio_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  fmt_e                fmt_i,
  input  logic                pend_vld_i,
  input  logic [SAMPLE_W-1:0] pend_l_i,
  input  logic [SAMPLE_W-1:0] pend_r_i,
  output logic                take_o,
  output logic                sd_o,
  output logic                ws_o,
  output logic                underrun_o
);
  localparam int FRAME = 2 * SLOT_W;
  localparam int PW    = $clog2(FRAME);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME - 1);

  logic [PW-1:0]       pos_q, pos_nxt;
  logic [SAMPLE_W-1:0] cur_l_q, cur_r_q, cur_l_nxt, cur_r_nxt;
  logic                sd_q, ws_q, under_q;
  logic                frame_start;
  logic                sd_nxt, ws_nxt;

  assign pos_nxt     = (pos_q == POS_LAST) ? '0 : pos_q + PW'(1);
  assign frame_start = fall_i & (pos_nxt == '0);
  assign take_o      = frame_start & pend_vld_i;
  assign cur_l_nxt   = take_o ? pend_l_i : cur_l_q;
  assign cur_r_nxt   = take_o ? pend_r_i : cur_r_q;

  // bit selection for the position about to be driven
  always_comb begin
    int                  p, k, sh;
    logic                right, hit;
    logic [SAMPLE_W-1:0] smp, sh_v;
    p     = int'(pos_nxt);
    right = (p >= SLOT_W);
    k     = right ? p - SLOT_W : p;
    smp   = right ? cur_r_nxt : cur_l_nxt;
    hit   = 1'b0;
    sh    = 0;
    ws_nxt = right;
    unique case (fmt_i)
      FMT_STD: begin
        ws_nxt = (p == FRAME - 1) ? 1'b0 : (p + 1 >= SLOT_W);
        if (k < SAMPLE_W) begin hit = 1'b1; sh = SAMPLE_W - 1 - k; end
      end
      FMT_LEFT: begin
        if (k < SAMPLE_W) begin hit = 1'b1; sh = SAMPLE_W - 1 - k; end
      end
      FMT_RIGHT: begin
        if (k >= SLOT_W - SAMPLE_W) begin hit = 1'b1; sh = SLOT_W - 1 - k; end
      end
      default: begin
        ws_nxt = (p == 0);
        if (p < SAMPLE_W) begin
          hit = 1'b1; smp = cur_l_nxt; sh = SAMPLE_W - 1 - p;
        end else if (p < 2 * SAMPLE_W) begin
          hit = 1'b1; smp = cur_r_nxt; sh = 2 * SAMPLE_W - 1 - p;
        end
      end
    endcase
    sh_v   = smp >> sh;
    sd_nxt = hit & sh_v[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= POS_LAST;
      cur_l_q <= '0;
      cur_r_q <= '0;
      sd_q    <= 1'b0;
      ws_q    <= 1'b0;
      under_q <= 1'b0;
    end else if (fall_i) begin
      pos_q   <= pos_nxt;
      cur_l_q <= cur_l_nxt;
      cur_r_q <= cur_r_nxt;
      sd_q    <= sd_nxt;
      ws_q    <= ws_nxt;
      if (frame_start) under_q <= ~pend_vld_i;
    end
  end

  assign sd_o       = sd_q;
  assign ws_o       = ws_q;
  assign underrun_o = under_q;

  a_r2_hold_between_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sd_o) && $stable(ws_o));
  a_r6_pulse_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && ws_o && fmt_i == FMT_PULSE |=> !ws_o);
  a_r4_slot_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && (fmt_i == FMT_LEFT || fmt_i == FMT_RIGHT) |=> ws_o == (int'(pos_q) >= SLOT_W));
  a_r9_repeat_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start && !pend_vld_i |=> underrun_o && $stable(cur_l_q) && $stable(cur_r_q));
  a_r9_clear_on_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !underrun_o);
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  logic                fall;
  logic                take;
  logic                pend_vld;
  logic [SAMPLE_W-1:0] pend_l, pend_r;

  initial begin
    if (SLOT_W < SAMPLE_W) $error("slot narrower than sample");
  end

  audio_ser_bclk #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_o (bclk_o),
    .fall_o (fall)
  );

  audio_ser_inbuf #(.SAMPLE_W(SAMPLE_W)) u_inbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .left_i     (left_i),
    .right_i    (right_i),
    .take_i     (take),
    .pend_vld_o (pend_vld),
    .pend_l_o   (pend_l),
    .pend_r_o   (pend_r)
  );

  audio_ser_frame #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .fmt_i      (fmt_e'(fmt_i)),
    .pend_vld_i (pend_vld),
    .pend_l_i   (pend_l),
    .pend_r_i   (pend_r),
    .take_o     (take),
    .sd_o       (sd_o),
    .ws_o       (ws_o),
    .underrun_o (underrun_o)
  );
endmodule

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int SL = 32;
  localparam int HD = 2;
  localparam int F  = 2 * SL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    fmt = 2'd0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_l = '0, in_r = '0;
  logic          bclk, ws, sd, under;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_ser_tx #(.SAMPLE_W(SW), .SLOT_W(SL), .HALF_DIV(HD)) u_audio_ser_tx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fmt_i      (fmt),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .left_i     (in_l),
    .right_i    (in_r),
    .bclk_o     (bclk),
    .ws_o       (ws),
    .sd_o       (sd),
    .underrun_o (under)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h fmt=%0d t=%0t", tag, act, exp, fmt, $time);
    end
  endtask

  // expected line values from the requirements, frame position p
  function automatic void line_at(input int f, input int p, input logic [SW-1:0] l,
                                  input logic [SW-1:0] r, output logic o_sd, output logic o_ws,
                                  output bit pad);
    int slot, off, b;
    logic [SW-1:0] d;
    slot = p / SL;
    off  = p % SL;
    d    = (slot == 1) ? r : l;
    b    = -1;
    case (f)
      0: begin o_ws = (((p + 1) % F) / SL) == 1; if (off < SW) b = SW - 1 - off; end
      1: begin o_ws = (slot == 1); if (off < SW) b = SW - 1 - off; end
      2: begin o_ws = (slot == 1); if (off >= SL - SW) b = SL - 1 - off; end
      default: begin
        o_ws = (p == 0);
        if (p < SW) begin d = l; b = SW - 1 - p; end
        else if (p < 2 * SW) begin d = r; b = 2 * SW - 1 - p; end
      end
    endcase
    pad  = (b < 0);
    o_sd = pad ? 1'b0 : d[b];
  endfunction

  function automatic string fmt_tag(input int f);
    case (f)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // handshake observed at the active edge
  logic          acc_q = 1'b0;
  logic [2*SW-1:0] acc_d = '0;
  always @(posedge clk) begin
    acc_q <= rst_n && in_valid && in_ready;
    acc_d <= {in_l, in_r};
  end

  // reference model, compared on every clock
  logic [2*SW-1:0] q[$];
  logic [SW-1:0]   m_l, m_r;
  logic            m_bclk, m_sd, m_ws, m_un;
  int              m_pos, half_cnt;
  bit              m_pad;

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_l = '0; m_r = '0; m_bclk = 1'b0; m_sd = 1'b0; m_ws = 1'b0; m_un = 1'b0;
      m_pos = F - 1; half_cnt = 0; m_pad = 1'b1;
      chk("R10 bclk", 32'(bclk), 32'd0);
      chk("R10 ws", 32'(ws), 32'd0);
      chk("R10 sd", 32'(sd), 32'd0);
      chk("R10 underrun", 32'(under), 32'd0);
      chk("R10 ready", 32'(in_ready), 32'd1);
    end else begin
      bit fell;
      fell = 1'b0;
      half_cnt++;
      if (bclk !== m_bclk) begin
        chk("R1 half period", 32'(half_cnt), 32'(HD));
        half_cnt = 0;
        fell = (m_bclk == 1'b1);
        m_bclk = bclk;
      end
      if (fell) begin
        m_pos = (m_pos + 1) % F;
        if (m_pos == 0) begin
          if (q.size() > 0) begin
            {m_l, m_r} = q.pop_front();
            m_un = 1'b0;
          end else begin
            m_un = 1'b1;
          end
        end
      end
      if (acc_q) q.push_back(acc_d);
      if (fell) line_at(int'(fmt), m_pos, m_l, m_r, m_sd, m_ws, m_pad);
      if (!fell) begin
        chk("R2 ws hold", 32'(ws), 32'(m_ws));
        chk("R2 sd hold", 32'(sd), 32'(m_sd));
      end else begin
        chk({fmt_tag(int'(fmt)), " ws"}, 32'(ws), 32'(m_ws));
        if (m_pad && fmt < 2'd2) chk("R7 pad zero", 32'(sd), 32'(m_sd));
        else chk({fmt_tag(int'(fmt)), " sd"}, 32'(sd), 32'(m_sd));
      end
      chk("R9 underrun", 32'(under), 32'(m_un));
      chk("R8 ready", 32'(in_ready), 32'(q.size() == 0));
    end
  end

  task automatic do_reset(input logic [1:0] f);
    @(negedge clk); #1 rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1 fmt = f;
    @(negedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic send(input int idx);
    @(negedge clk);
    #1;
    in_valid = 1'b1;
    in_l = SW'((32'h00A53C01 * (idx + 3)) ^ 32'h005A5A5A);
    in_r = SW'(32'h00F00F35 ^ (idx * 32'h00011111));
    do @(negedge clk); while (!acc_q);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    for (int f = 0; f < 4; f++) begin
      do_reset(2'(f));
      for (int i = 0; i < 4; i++) send(i + 10 * f);
      repeat (3 * F * 2 * HD) @(negedge clk);
      send(5 + 10 * f);
      send(6 + 10 * f);
      repeat (3 * F * 2 * HD) @(negedge clk);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule